// File: doc/BRIEF.md
# EEPROM Page-Write Load Controller

This block is the device-side write path of a bytewide parallel EEPROM model, built as synchronous logic. It brings the asynchronous active-low chip-enable, write-enable and output-enable strobes into the system clock domain. The address and data buses pass through the same synchronizer depth, so they stay aligned with the strobes. Each recognised write cycle is a byte load. Byte loads that share one page are collected in a page buffer, and a per-byte mark records which offsets were loaded.

When loads stop arriving within a fixed window, the page is closed and a self-timed programming cycle begins. During that cycle the block drives a commit port toward the storage array. The port carries one byte per clock, and only for the offsets that were loaded. Busy stays high for the whole cycle. The address and data of the last accepted load are held for a separate status block. The window length and the programming time are parameters in clock cycles.

Top module: `eeprom_page_loader`

## Requirements
- R1: After reset, `busy` and `arr_we` are low, and `last_addr` and `last_data` are zero.
- R2: A byte load occurs only while chip-enable and write-enable are both low and output-enable is high. Strobes that are low while output-enable is low load nothing and never start programming.
- R3: The load address is the value on `addr` when the later of the two enable strobes falls. It may change freely afterwards.
- R4: The load data is the value on `din` when the earlier of the two enable strobes rises. It may change freely afterwards.
- R5: `addr[15:7]` is the page and `addr[6:0]` is the byte offset in it. Every commit write in one programming cycle carries the page of the first load, with the offset in bits 6..0.
- R6: One page operation accepts up to 128 loads, one for every offset, and commits all of them.
- R7: In an open page operation, a load whose page differs from the latched page is ignored. It writes nothing, does not change `last_addr`/`last_data`, and does not restart the window.
- R8: Each accepted load restarts the window, so loads spaced closer than `WINDOW_CYC` keep the page open regardless of total duration.
- R9: When `WINDOW_CYC` cycles pass after the start of the last accepted load and no load is in progress, programming starts and `busy` rises.
- R10: `busy` stays high for exactly `PROG_CYC` cycles. Write strobes during that time are ignored and leave no pending load.
- R11: A programming cycle writes only the loaded offsets, in ascending offset order, once each. A reloaded offset is written with its newest data.
- R12: `last_addr` and `last_data` hold the full address and data of the most recent accepted load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | 16 | Byte address: page in 15..7, offset in 6..0 |
| din | input | 8 | Write data |
| busy | output | 1 | High during the self-timed programming cycle |
| last_addr | output | 16 | Address of the last accepted load |
| last_data | output | 8 | Data of the last accepted load |
| arr_we | output | 1 | Commit write strobe toward the array |
| arr_addr | output | 16 | Commit write address |
| arr_data | output | 8 | Commit write data |

## Verification
The hardest case to reach from the ports is a foreign-page load arriving while a page is open. Its effect can only be seen in when programming begins, since it changes neither the commit writes nor the status outputs. The stimulus places that load far enough after the first one that, had it restarted the window, `busy` would rise about 25 cycles later than it should. The bench then bounds the wait for `busy`. The edge-ordering cases are set up in a similar way: `addr` and `din` are changed while the strobes are still low, so that only a capture at the correct edge yields the expected values.

// File: rtl/eeprom_page_loader.sv
module eeprom_page_loader #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int OFFS_W      = 7,
  parameter int SYNC_STAGES = 2,
  parameter int WINDOW_CYC  = 12500,
  parameter int PROG_CYC    = 625000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              busy,
  output logic [ADDR_W-1:0] last_addr,
  output logic [DATA_W-1:0] last_data,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data
);

  localparam int PAGE_BYTES = 1 << OFFS_W;
  localparam int PAGE_W     = ADDR_W - OFFS_W;
  localparam int TW         = $clog2(WINDOW_CYC + 1);
  localparam int PW         = $clog2(PROG_CYC + 1);
  localparam int SL         = SYNC_STAGES - 1;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} state_t;

  logic [SYNC_STAGES-1:0] ce_sr, we_sr, oe_sr;
  logic [ADDR_W-1:0]      addr_sr [SYNC_STAGES];
  logic [DATA_W-1:0]      din_sr  [SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_sr <= '1;
      we_sr <= '1;
      oe_sr <= '1;
      for (int i = 0; i < SYNC_STAGES; i++) begin
        addr_sr[i] <= '0;
        din_sr[i]  <= '0;
      end
    end else begin
      ce_sr      <= {ce_sr[SYNC_STAGES-2:0], ce_n};
      we_sr      <= {we_sr[SYNC_STAGES-2:0], we_n};
      oe_sr      <= {oe_sr[SYNC_STAGES-2:0], oe_n};
      addr_sr[0] <= addr;
      din_sr[0]  <= din;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        addr_sr[i] <= addr_sr[i-1];
        din_sr[i]  <= din_sr[i-1];
      end
    end
  end

  wire [ADDR_W-1:0] addr_s = addr_sr[SL];
  wire [DATA_W-1:0] din_s  = din_sr[SL];
  wire              wr_act = !ce_sr[SL] && !we_sr[SL] && oe_sr[SL];

  state_t                  st;
  logic                    act_q;
  logic                    open_q;
  logic [PAGE_W-1:0]       page_q;
  logic [OFFS_W-1:0]       offs_q;
  logic [TW-1:0]           tmr;
  logic [PW-1:0]           pcnt;
  logic [PAGE_BYTES-1:0]   loaded;
  logic [DATA_W-1:0]       pbuf [PAGE_BYTES];

  wire act_rise   = wr_act && !act_q;
  wire act_fall   = !wr_act && act_q;
  wire same_page  = addr_s[ADDR_W-1:OFFS_W] == page_q;
  wire tmr_sat    = tmr == TW'(WINDOW_CYC);
  wire win_over   = tmr >= TW'(WINDOW_CYC - 1);
  wire commit_ld  = (st == ST_LOAD) && act_fall && open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      act_q     <= 1'b0;
      open_q    <= 1'b0;
      page_q    <= '0;
      offs_q    <= '0;
      tmr       <= '0;
      pcnt      <= '0;
      loaded    <= '0;
      last_addr <= '0;
      last_data <= '0;
    end else begin
      act_q <= wr_act;
      unique case (st)
        ST_IDLE: if (act_rise) begin
          page_q <= addr_s[ADDR_W-1:OFFS_W];
          offs_q <= addr_s[OFFS_W-1:0];
          open_q <= 1'b1;
          tmr    <= '0;
          st     <= ST_LOAD;
        end
        ST_LOAD: begin
          if (act_rise && same_page) begin
            offs_q <= addr_s[OFFS_W-1:0];
            open_q <= 1'b1;
            tmr    <= '0;
          end else begin
            if (commit_ld) begin
              loaded[offs_q] <= 1'b1;
              last_addr      <= {page_q, offs_q};
              last_data      <= din_s;
              open_q         <= 1'b0;
            end
            if (win_over && !open_q) begin
              st   <= ST_PROG;
              pcnt <= '0;
            end else if (!tmr_sat) begin
              tmr <= tmr + TW'(1);
            end
          end
        end
        ST_PROG: begin
          pcnt <= pcnt + PW'(1);
          if (pcnt == PW'(PROG_CYC - 1)) begin
            st     <= ST_IDLE;
            loaded <= '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (commit_ld) pbuf[offs_q] <= din_s;
  end

  wire [OFFS_W-1:0] scan = pcnt[OFFS_W-1:0];

  assign busy     = st == ST_PROG;
  assign arr_we   = busy && (pcnt < PW'(PAGE_BYTES)) && loaded[scan];
  assign arr_addr = {page_q, scan};
  assign arr_data = pbuf[scan];

endmodule

// File: rtl/eeprom_page_loader_chk.sv
module eeprom_page_loader_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int OFFS_W   = 7,
  parameter int PROG_CYC = 625000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [ADDR_W-1:0] last_addr,
  input logic [DATA_W-1:0] last_data
);

  int unsigned busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= 0;
  end

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);  // R11

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> busy_len == PROG_CYC);  // R10

  AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(last_addr) && $stable(last_data)));  // R10

  AST_PAGE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> arr_addr[ADDR_W-1:OFFS_W] == $past(arr_addr[ADDR_W-1:OFFS_W]));  // R5

  AST_PAGE_MATCHES_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> arr_addr[ADDR_W-1:OFFS_W] == last_addr[ADDR_W-1:OFFS_W]);  // R12

endmodule

bind eeprom_page_loader eeprom_page_loader_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFFS_W(OFFS_W), .PROG_CYC(PROG_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .arr_we(arr_we),
  .arr_addr(arr_addr), .last_addr(last_addr), .last_data(last_data)
);

// File: tb/test_eeprom_page_loader.sv
`timescale 1ns/1ps
module test_eeprom_page_loader;

  localparam int WIN  = 40;
  localparam int PROG = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0;
  logic        busy, arr_we;
  logic [15:0] last_addr, arr_addr;
  logic [7:0]  last_data, arr_data;

  eeprom_page_loader #(.WINDOW_CYC(WIN), .PROG_CYC(PROG)) i_eeprom_page_loader (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .busy(busy), .last_addr(last_addr), .last_data(last_data),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int wr_n = 0, busy_cnt = 0;
  logic [15:0] log_a [256];
  logic [7:0]  log_d [256];

  always @(negedge clk) begin
    if (arr_we && wr_n < 256) begin
      log_a[wr_n] = arr_addr;
      log_d[wr_n] = arr_data;
      wr_n++;
    end
    if (busy) busy_cnt++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_logs();
    wr_n = 0;
    busy_cnt = 0;
  endtask

  task automatic load_we(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = ~a; din = ~d; ce_n = 1'b0;
    tick(1); addr = a; din = d;
    tick(1); we_n = 1'b0;
    tick(3); addr = ~a;
    tick(1); we_n = 1'b1;
    tick(1); din = ~d;
    tick(1); ce_n = 1'b1;
    tick(2);
  endtask

  task automatic wait_busy(input int lim, output int waited);
    waited = 0;
    while (!busy && waited < lim) begin tick(1); waited++; end
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < PROG + 50) begin tick(1); n++; end
    tick(2);
  endtask

  task automatic t_reset();
    check(busy == 0,      "R1 busy", busy, 0);
    check(arr_we == 0,    "R1 arr_we", arr_we, 0);
    check(last_addr == 0, "R1 last_addr", last_addr, 0);
    check(last_data == 0, "R1 last_data", last_data, 0);
  endtask

  task automatic t_single_we();
    int w;
    clear_logs();
    load_we(16'h1A85, 8'h5C);
    check(busy == 0, "R9 busy before window", busy, 0);
    check(last_addr == 16'h1A85, "R3 address at later fall", last_addr, 16'h1A85);
    check(last_data == 8'h5C, "R4 data at earlier rise", last_data, 8'h5C);
    wait_busy(WIN + 20, w);
    check(busy && w >= 25 && w <= 45, "R9 start after window", w, WIN - 8);
    wait_idle();
    check(busy_cnt == PROG, "R10 busy length", busy_cnt, PROG);
    check(wr_n == 1, "R11 one write", wr_n, 1);
    check(log_a[0] == 16'h1A85 && log_d[0] == 8'h5C, "R5 commit addr/data",
          {log_a[0], log_d[0]}, {16'h1A85, 8'h5C});
  endtask

  task automatic t_ce_controlled();
    int w;
    clear_logs();
    @(negedge clk);
    addr = 16'hFFFF; din = 8'h00; we_n = 1'b0;
    tick(2); addr = 16'h4321; din = 8'hEE;
    tick(3); ce_n = 1'b0;
    tick(3); addr = 16'hBEEF; din = 8'h96;
    tick(3); ce_n = 1'b1;
    tick(1); din = 8'h11;
    tick(3); we_n = 1'b1;
    tick(2);
    check(last_addr == 16'h4321, "R3 CE-controlled address", last_addr, 16'h4321);
    check(last_data == 8'h96, "R4 CE-controlled data", last_data, 8'h96);
    wait_busy(WIN + 20, w);
    wait_idle();
    check(wr_n == 1 && log_a[0] == 16'h4321 && log_d[0] == 8'h96, "R3 CE-controlled commit",
          {log_a[0], log_d[0]}, {16'h4321, 8'h96});
  endtask

  task automatic t_oe_block();
    clear_logs();
    @(negedge clk);
    addr = 16'h0123; din = 8'h77; oe_n = 1'b0; ce_n = 1'b0;
    tick(1); we_n = 1'b0;
    tick(6); we_n = 1'b1; ce_n = 1'b1;
    tick(1); oe_n = 1'b1;
    tick(2 * WIN);
    check(busy_cnt == 0 && busy == 0, "R2 no programming with OE low", busy_cnt, 0);
    check(last_addr == 16'h4321, "R2 status unchanged", last_addr, 16'h4321);
  endtask

  task automatic t_spacing();
    int w, bad;
    clear_logs();
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      load_we({9'h0A2, 7'(i * 5)}, 8'(8'h30 + i));
      if (busy) bad++;
      tick(WIN - 16);
      if (busy) bad++;
    end
    check(bad == 0, "R8 page held open by spaced loads", bad, 0);
    wait_busy(WIN + 20, w);
    wait_idle();
    check(wr_n == 6, "R8 all spaced loads committed", wr_n, 6);
    bad = 0;
    for (int i = 0; i < 6; i++)
      if (log_a[i] != {9'h0A2, 7'(i * 5)} || log_d[i] != 8'(8'h30 + i)) bad++;
    check(bad == 0, "R11 spaced commit contents", bad, 0);
  endtask

  task automatic t_full_page();
    int w, bad;
    clear_logs();
    for (int i = 127; i >= 0; i--) load_we({9'h13F, 7'(i)}, 8'(i) ^ 8'hA5);
    check(busy_cnt == 0, "R6 no programming during 128 loads", busy_cnt, 0);
    wait_busy(WIN + 20, w);
    wait_idle();
    check(wr_n == 128, "R6 128 writes", wr_n, 128);
    bad = 0;
    for (int i = 0; i < 128; i++)
      if (log_a[i] != {9'h13F, 7'(i)} || log_d[i] != (8'(i) ^ 8'hA5)) bad++;
    check(bad == 0, "R5 ascending page commit", bad, 0);
    check(last_addr == {9'h13F, 7'd0}, "R12 last address of page", last_addr, {9'h13F, 7'd0});
  endtask

  task automatic t_sparse();
    int w;
    clear_logs();
    load_we({9'h055, 7'd77}, 8'h21);
    load_we({9'h055, 7'd3},  8'h42);
    load_we({9'h055, 7'd77}, 8'h99);
    check(last_addr == {9'h055, 7'd77} && last_data == 8'h99, "R12 last load status",
          {last_addr, last_data}, {9'h055, 7'd77, 8'h99});
    wait_busy(WIN + 20, w);
    wait_idle();
    check(wr_n == 2, "R11 only loaded offsets", wr_n, 2);
    check(log_a[0] == {9'h055, 7'd3} && log_d[0] == 8'h42, "R11 first sparse write",
          {log_a[0], log_d[0]}, {9'h055, 7'd3, 8'h42});
    check(log_a[1] == {9'h055, 7'd77} && log_d[1] == 8'h99, "R11 reloaded offset newest data",
          {log_a[1], log_d[1]}, {9'h055, 7'd77, 8'h99});
  endtask

  task automatic t_mismatch();
    int w;
    clear_logs();
    load_we({9'h100, 7'd5}, 8'hC3);
    tick(15);
    load_we({9'h101, 7'd9}, 8'h3C);
    check(last_addr == {9'h100, 7'd5} && last_data == 8'hC3, "R7 foreign load leaves status",
          {last_addr, last_data}, {9'h100, 7'd5, 8'hC3});
    wait_busy(WIN + 40, w);
    check(busy && w <= 20, "R7 foreign load does not restart window", w, 10);
    wait_idle();
    check(wr_n == 1 && log_a[0] == {9'h100, 7'd5}, "R7 foreign load not committed",
          log_a[0], {9'h100, 7'd5});
  endtask

  task automatic t_busy_ignore();
    int w;
    clear_logs();
    load_we(16'h2222, 8'h44);
    wait_busy(WIN + 20, w);
    tick(5);
    load_we(16'h2223, 8'h55);
    check(last_addr == 16'h2222, "R10 load during busy ignored", last_addr, 16'h2222);
    wait_idle();
    check(busy_cnt == PROG, "R10 busy length with strobes", busy_cnt, PROG);
    clear_logs();
    tick(2 * WIN);
    check(busy_cnt == 0 && wr_n == 0, "R10 no pending load after busy", busy_cnt, 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_single_we();
    t_ce_controlled();
    t_oe_block();
    t_spacing();
    t_full_page();
    t_sparse();
    t_mismatch();
    t_busy_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule